// File: doc/BRIEF.md
# Interrupt Acknowledge Byte Responder

This block supplies the bytes that an interrupt controller places on the processor data bus while the processor runs an interrupt acknowledge sequence. Each acknowledge strobe asks for one byte. The block knows which byte of the sequence is due, and from that it decides whether this device drives the bus and what value it drives. Two processor styles are supported. In call style, three acknowledges fetch a call opcode and a 16-bit routine address. In that address the interrupt level is merged at a stride of 4 or 8 bytes. In vector style, two acknowledges are used: the first drives nothing, and the second fetches a single vector byte.

Cascading is handled on three cascade lines. A master that has a slave attached to the acknowledged line drives only the opcode, and it puts the level on the cascade lines. A slave drives its address or vector bytes only when the cascade input matches its own identity. The level, the base address and the mode bits are captured on the first acknowledge of a sequence. The values in effect for a whole sequence come from that capture. Priority resolution and register programming happen upstream.

Top module: `irq_ack_responder`

## Requirements
- R1: While reset is asserted, and at its release, data_oe_o is 0, data_o is 0x00 and cas_o is 0.
- R2: An acknowledge sampled at a rising clock edge produces its response in the following cycle. When the block drives, data_oe_o is 1 and data_o holds the byte. When it does not drive, data_oe_o is 0 and data_o is 0x00. data_oe_o is never 1 unless ack_i was 1 at the previous edge.
- R3: In call style (vec_mode_i=0) a sequence has three acknowledges. A master answers the first with 0xCD.
- R4: In call style with stride4_i=1 the routine address is {base_addr_i[15:5], level, 2'b00}. The second byte is address bits 7:0 and the third is bits 15:8.
- R5: In call style with stride4_i=0 the routine address is {base_addr_i[15:6], level, 3'b000}. The bytes are ordered as in R4.
- R6: In vector style (vec_mode_i=1) a sequence has two acknowledges. Nothing is driven on the first. The second carries {base_addr_i[15:11], level}, and stride4_i has no effect.
- R7: cas_o is 0 whenever no sequence is in progress. In a master whose slave_map_i bit for the acknowledged level is 1, cas_o equals the level from the cycle after the first acknowledge until the last acknowledge's edge. In that case the master drives no byte after the first.
- R8: A master whose slave_map_i bit for the level is 0 drives every byte of the sequence and keeps cas_o at 0.
- R9: A slave (master_i=0) never drives the first byte. It drives each later byte only if cas_i equals slave_id_i at that acknowledge, and it keeps cas_o at 0.
- R10: The level, base address, stride and style are captured on the first acknowledge. Changes to these inputs later in the same sequence do not alter the bytes that are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_i | input | 1 | One-cycle acknowledge strobe, one per byte |
| level_i | input | 3 | Resolved interrupt level |
| base_addr_i | input | 16 | Programmed routine base address / vector high bits |
| stride4_i | input | 1 | 1: 4-byte address stride, 0: 8-byte stride |
| vec_mode_i | input | 1 | 0: three-byte call style, 1: single vector byte |
| master_i | input | 1 | 1: this device is the cascade master |
| slave_map_i | input | 8 | Master: bit n set means a slave sits on line n |
| slave_id_i | input | 3 | Slave: own cascade identity |
| cas_i | input | 3 | Cascade lines as seen by a slave |
| data_o | output | 8 | Response byte |
| data_oe_o | output | 1 | Data bus drive enable |
| cas_o | output | 3 | Cascade lines driven by a master |

## Verification
The assertions check on every cycle that the drive enable follows an acknowledge (R2), and that a master's first call byte is always the opcode (R3). They also check that the first vector-style acknowledge stays silent (R6), that a slave with a mismatching cascade input never drives (R9), and that the cascade lines rest at zero between sequences (R7). The arithmetic of the merged address and vector bytes, the split of bytes between master and slave, and the capture of inputs on the first acknowledge can only be shown by the bench's sweeps. Those sweeps cover all levels, both strides, both styles, slave maps, and every identity and cascade pairing.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int unsigned LVL_W_DEF  = 3;
  localparam int unsigned ADDR_W_DEF = 16;
  localparam int unsigned BYTE_W_DEF = 8;

  typedef enum logic [1:0] {
    POS_OP = 2'd0,
    POS_LO = 2'd1,
    POS_HI = 2'd2
  } byte_pos_e;
endpackage

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_ack_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ack_i,
  input  logic      vec_eff_i,
  output byte_pos_e pos_o,
  output logic      idle_o,
  output logic      last_o
);
  byte_pos_e pos_q;

  assign idle_o = (pos_q == POS_OP);
  assign last_o = ack_i & (vec_eff_i ? (pos_q == POS_LO) : (pos_q == POS_HI));
  assign pos_o  = pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= POS_OP;
    end else if (ack_i) begin
      if (last_o) pos_q <= POS_OP;
      else        pos_q <= byte_pos_e'(pos_q + 2'd1);
    end
  end
endmodule

// File: rtl/irq_ack_ctx.sv
module irq_ack_ctx #(
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_i,
  input  logic              idle_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              stride4_i,
  input  logic              vec_i,
  output logic [LVL_W-1:0]  level_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              stride4_o,
  output logic              vec_o
);
  localparam int unsigned CTX_W = LVL_W + ADDR_W + 2;

  logic [CTX_W-1:0] live, held_q;

  assign live = {level_i, base_i, stride4_i, vec_i};

  always_ff @(posedge clk) begin
    if (!rst_n)               held_q <= '0;
    else if (ack_i && idle_i) held_q <= live;
  end

  // The first byte of a sequence uses live inputs; later bytes use the capture.
  assign {level_o, base_o, stride4_o, vec_o} = idle_i ? live : held_q;
endmodule

// File: rtl/irq_ack_fmt.sv
module irq_ack_fmt
  import irq_ack_pkg::*;
#(
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned BYTE_W  = 8,
  parameter logic [7:0]  CALL_OP = 8'hCD
) (
  input  byte_pos_e         pos_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              stride4_i,
  input  logic              vec_i,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int unsigned LOW4  = LVL_W + 2;
  localparam int unsigned LOW8  = LVL_W + 3;
  localparam int unsigned VHI_W = BYTE_W - LVL_W;

  logic [ADDR_W-1:0] addr4, addr8, addr;
  logic [BYTE_W-1:0] vec_byte;
  logic              unused_low;

  assign addr4    = {base_i[ADDR_W-1:LOW4], level_i, 2'b00};
  assign addr8    = {base_i[ADDR_W-1:LOW8], level_i, 3'b000};
  assign addr     = stride4_i ? addr4 : addr8;
  assign vec_byte = {base_i[ADDR_W-1 -: VHI_W], level_i};
  assign unused_low = ^base_i[1:0];

  always_comb begin
    unique case (pos_i)
      POS_OP:  byte_o = CALL_OP;
      POS_LO:  byte_o = vec_i ? vec_byte : addr[BYTE_W-1:0];
      default: byte_o = addr[2*BYTE_W-1:BYTE_W];
    endcase
  end
endmodule

// File: rtl/irq_ack_route.sv
module irq_ack_route
  import irq_ack_pkg::*;
#(
  parameter int unsigned LVL_W = 3,
  localparam int unsigned LINES = 1 << LVL_W
) (
  input  byte_pos_e        pos_i,
  input  logic             vec_i,
  input  logic             master_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LINES-1:0] slave_map_i,
  input  logic [LVL_W-1:0] slave_id_i,
  input  logic [LVL_W-1:0] cas_i,
  output logic             drive_o,
  output logic             attached_o
);
  assign attached_o = master_i & slave_map_i[level_i];

  always_comb begin
    if (pos_i == POS_OP) drive_o = master_i & ~vec_i;
    else if (master_i)   drive_o = ~attached_o;
    else                 drive_o = (cas_i == slave_id_i);
  end
endmodule

// File: rtl/irq_ack_responder.sv
module irq_ack_responder
  import irq_ack_pkg::*;
#(
  parameter int unsigned LVL_W   = LVL_W_DEF,
  parameter int unsigned ADDR_W  = ADDR_W_DEF,
  parameter int unsigned BYTE_W  = BYTE_W_DEF,
  parameter logic [7:0]  CALL_OP = 8'hCD,
  localparam int unsigned LINES  = 1 << LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              stride4_i,
  input  logic              vec_mode_i,
  input  logic              master_i,
  input  logic [LINES-1:0]  slave_map_i,
  input  logic [LVL_W-1:0]  slave_id_i,
  input  logic [LVL_W-1:0]  cas_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_oe_o,
  output logic [LVL_W-1:0]  cas_o
);
  byte_pos_e         pos;
  logic              seq_idle, seq_last;
  logic [LVL_W-1:0]  lvl_e;
  logic [ADDR_W-1:0] base_e;
  logic              stride_e, vec_e;
  logic [BYTE_W-1:0] byte_v;
  logic              drive, attached;
  logic [BYTE_W-1:0] data_q;
  logic              oe_q;
  logic [LVL_W-1:0]  cas_q;

  irq_ack_seq seq_u (
    .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .vec_eff_i(vec_e),
    .pos_o(pos), .idle_o(seq_idle), .last_o(seq_last)
  );

  irq_ack_ctx #(.LVL_W(LVL_W), .ADDR_W(ADDR_W)) ctx_u (
    .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .idle_i(seq_idle),
    .level_i(level_i), .base_i(base_addr_i), .stride4_i(stride4_i), .vec_i(vec_mode_i),
    .level_o(lvl_e), .base_o(base_e), .stride4_o(stride_e), .vec_o(vec_e)
  );

  irq_ack_fmt #(.LVL_W(LVL_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .CALL_OP(CALL_OP)) fmt_u (
    .pos_i(pos), .level_i(lvl_e), .base_i(base_e), .stride4_i(stride_e),
    .vec_i(vec_e), .byte_o(byte_v)
  );

  irq_ack_route #(.LVL_W(LVL_W)) route_u (
    .pos_i(pos), .vec_i(vec_e), .master_i(master_i), .level_i(lvl_e),
    .slave_map_i(slave_map_i), .slave_id_i(slave_id_i), .cas_i(cas_i),
    .drive_o(drive), .attached_o(attached)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      oe_q   <= 1'b0;
      cas_q  <= '0;
    end else begin
      oe_q   <= ack_i & drive;
      data_q <= (ack_i && drive) ? byte_v : '0;
      if (ack_i && seq_last)      cas_q <= '0;
      else if (ack_i && seq_idle) cas_q <= attached ? lvl_e : '0;
    end
  end

  assign data_o    = data_q;
  assign data_oe_o = oe_q;
  assign cas_o     = cas_q;
endmodule

// File: rtl/irq_ack_responder_chk.sv
module irq_ack_responder_chk #(
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_i,
  input logic              vec_mode_i,
  input logic              master_i,
  input logic [LVL_W-1:0]  cas_i,
  input logic [LVL_W-1:0]  slave_id_i,
  input logic              idle_i,
  input logic [BYTE_W-1:0] data_o,
  input logic              data_oe_o,
  input logic [LVL_W-1:0]  cas_o
);
  a_r2_oe_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> $past(ack_i));

  a_r3_opcode_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && idle_i && !vec_mode_i && master_i) |=> (data_oe_o && data_o == 8'hCD));

  a_r6_vector_first_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && idle_i && vec_mode_i) |=> !data_oe_o);

  a_r9_slave_mismatch_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !idle_i && !master_i && cas_i != slave_id_i) |=> !data_oe_o);

  a_r7_cas_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    idle_i |-> (cas_o == '0));
endmodule

bind irq_ack_responder irq_ack_responder_chk #(.LVL_W(LVL_W), .BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .vec_mode_i(vec_mode_i),
  .master_i(master_i), .cas_i(cas_i), .slave_id_i(slave_id_i), .idle_i(seq_idle),
  .data_o(data_o), .data_oe_o(data_oe_o), .cas_o(cas_o)
);

// File: tb/irq_ack_responder_tb_top.sv
`timescale 1ns/1ps
module irq_ack_responder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ack = 1'b0;
  logic [2:0]  level = '0;
  logic [15:0] base = '0;
  logic        s4 = 1'b0, vec = 1'b0, mst = 1'b1;
  logic [7:0]  smap = '0;
  logic [2:0]  sid = '0, casi = '0;
  logic [7:0]  d;
  logic        oe;
  logic [2:0]  caso;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_ack_responder dut_i (
    .clk(clk), .rst_n(rst_n), .ack_i(ack), .level_i(level), .base_addr_i(base),
    .stride4_i(s4), .vec_mode_i(vec), .master_i(mst), .slave_map_i(smap),
    .slave_id_i(sid), .cas_i(casi), .data_o(d), .data_oe_o(oe), .cas_o(caso)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Starts at a negedge: strobe one acknowledge, then sample the response cycle.
  task automatic pulse(input string req, input logic eoe, input logic [7:0] ed, input logic [2:0] ecas);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(req, "oe", {31'd0, oe}, {31'd0, eoe});
    chk(req, "data", {24'd0, d}, {24'd0, ed});
    chk(req, "cas", {29'd0, caso}, {29'd0, ecas});
  endtask

  function automatic logic [15:0] exp_addr(input logic [15:0] b, input int lv, input logic st4);
    if (st4) return (b & 16'hFFE0) | 16'(lv * 4);
    else     return (b & 16'hFFC0) | 16'(lv * 8);
  endfunction

  function automatic logic [7:0] exp_vec(input logic [15:0] b, input int lv);
    return 8'(((b >> 11) * 8) + lv);
  endfunction

  task automatic run_seq(input logic m, input logic v, input logic st4, input int lv,
                         input logic [15:0] b, input logic [7:0] sm, input logic [2:0] id,
                         input logic [2:0] ci, input string req);
    logic att, drv;
    logic [15:0] a;
    logic [2:0] ec;
    mst = m; vec = v; s4 = st4; level = 3'(lv); base = b; smap = sm; sid = id; casi = ci;
    att = m && sm[lv];
    drv = m ? !att : (ci == id);
    ec  = att ? 3'(lv) : 3'd0;
    a   = exp_addr(b, lv, st4);
    if (!v) begin
      pulse(req, m, m ? 8'hCD : 8'h00, ec);
      pulse(req, drv, drv ? a[7:0] : 8'h00, ec);
      pulse(req, drv, drv ? a[15:8] : 8'h00, 3'd0);
    end else begin
      pulse(req, 1'b0, 8'h00, ec);
      pulse(req, drv, drv ? exp_vec(b, lv) : 8'h00, 3'd0);
    end
    @(negedge clk);
    chk(req, "idle oe", {31'd0, oe}, 32'd0);
    chk("R7", "idle cas", {29'd0, caso}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "oe", {31'd0, oe}, 32'd0);
    chk("R1", "data", {24'd0, d}, 32'd0);
    chk("R1", "cas", {29'd0, caso}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "oe after release", {31'd0, oe}, 32'd0);

    // R2 R3 R4 R5 R6 R8: master with no slaves, all levels, strides and styles
    for (int b = 0; b < 2; b++)
      for (int v = 0; v < 2; v++)
        for (int st = 0; st < 2; st++)
          for (int lv = 0; lv < 8; lv++)
            run_seq(1'b1, v[0], st[0], lv, (b == 0) ? 16'hA5F3 : 16'h1C0B, 8'h00, 3'd0, 3'd0,
                    v[0] ? "R6" : (st[0] ? "R4" : "R5"));

    // R7 R8: master with a mixed slave map
    for (int v = 0; v < 2; v++)
      for (int lv = 0; lv < 8; lv++)
        run_seq(1'b1, v[0], 1'b0, lv, 16'h7E44, 8'b1010_0101, 3'd0, 3'd0, "R7");

    // R9: slave, every identity against every cascade value
    for (int v = 0; v < 2; v++)
      for (int id = 0; id < 8; id++)
        for (int ci = 0; ci < 8; ci++)
          run_seq(1'b0, v[0], 1'b1, id ^ 3, 16'h3C96, 8'hFF, 3'(id), 3'(ci), "R9");

    // R10: inputs changed after the first acknowledge are not used
    mst = 1'b1; vec = 1'b0; s4 = 1'b1; level = 3'd5; base = 16'hB2C0; smap = 8'h00;
    pulse("R10", 1'b1, 8'hCD, 3'd0);
    level = 3'd2; base = 16'h0000; s4 = 1'b0; vec = 1'b1;
    pulse("R10", 1'b1, 8'hD4, 3'd0);
    pulse("R10", 1'b1, 8'hB2, 3'd0);
    @(negedge clk);
    chk("R2", "idle oe", {31'd0, oe}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule